// File: doc/BRIEF.md
# Unaligned Row Byte Aligner

The block takes one row of pixels that begins at an arbitrary byte address and turns it into packed words for the datapath that follows. The fetch logic clears the two low bits of the source address and reads three consecutive aligned words from there. It passes the two dropped bits to this block as a byte offset.

The block returns four packed words. The first two hold the eight pixels that begin at the offset. The other two hold the eight pixels that begin one byte later, which a horizontal half-pixel filter needs. Three aligned words always contain the nine bytes of a row, whatever the offset. The block is purely combinational and all four words are valid in the same cycle as the inputs.

Top module: `row_byte_aligner`

## Requirements
- R1: The fetch stream is the 12 bytes of the three input words. Stream byte k is bits [8*(k%4)+7 : 8*(k%4)] of fetch word k/4 (little-endian). The byte offset input equals the source address modulo 4.
- R2: `row_w0_o` holds stream bytes ofs, ofs+1, ofs+2 and ofs+3. Byte ofs sits in bits 7:0 and each following byte sits 8 bits higher.
- R3: `row_w1_o` holds stream bytes ofs+4 to ofs+7, with ofs+4 in bits 7:0.
- R4: `nxt_w0_o` holds stream bytes ofs+1 to ofs+4, with ofs+1 in bits 7:0.
- R5: `nxt_w1_o` holds stream bytes ofs+5 to ofs+8, with ofs+5 in bits 7:0.
- R6: At offset 0, `row_w0_o` and `row_w1_o` equal fetch words 0 and 1 unchanged. The shifted words are those words moved right by 8 bits, with the top byte taken from the next fetch word.
- R7: At offset 3, `nxt_w0_o` and `nxt_w1_o` equal fetch words 1 and 2 unchanged, and bits 7:0 of `row_w0_o` equal bits 31:24 of fetch word 0.
- R8: No output depends on stream bytes outside the nine-byte window ofs..ofs+8. Changing only those bytes leaves all four outputs unchanged.
- R9: The block has no clock and no state. The outputs for a given set of inputs are valid in the same cycle, whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_ofs_i | input | 2 | Source address modulo 4 |
| fetch_w0_i | input | 32 | Aligned word at the truncated address |
| fetch_w1_i | input | 32 | Next aligned word |
| fetch_w2_i | input | 32 | Third aligned word |
| row_w0_o | output | 32 | Row pixels 0..3 |
| row_w1_o | output | 32 | Row pixels 4..7 |
| nxt_w0_o | output | 32 | Row pixels 1..4 (one-pixel-shifted copy) |
| nxt_w1_o | output | 32 | Row pixels 5..8 (one-pixel-shifted copy) |

## Verification
The unshifted row and the one-pixel-shifted copy always come from the same input in the same cycle. Stream bytes ofs+1 to ofs+7 reach both, in different lanes. To make any lane swap or wrong selection show up, the bench applies a new offset and new random words every cycle, plus byte patterns where every byte is distinct. It compares all four words against a byte-list model each cycle. A second phase tests the window boundary. It holds the offset, replaces only the bytes outside the nine-byte window on the next cycle, and requires every output to match the previous cycle's outputs exactly.

// File: rtl/row_aligner_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing for the row byte aligner.
// Assumes pixels are packed LSB-first inside each aligned fetch word.
package row_aligner_pkg;
    localparam int unsigned PIX_W_DEF = 8;
    localparam int unsigned LANES_DEF = 4;

    // Number of aligned words needed to cover span pixels at any offset.
    function automatic int unsigned words_needed(input int unsigned span, input int unsigned lanes);
        return (span + lanes - 1 + lanes - 1) / lanes;
    endfunction
endpackage

// File: rtl/fetch_unpack.sv
`timescale 1ns/1ps
// Module: fetch_unpack
// Splits the fetched aligned words into one flat little-endian byte stream.
// Assumes word 0 is the lowest address and lane 0 the lowest byte of a word.
module fetch_unpack #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned WORDS = 3,
    localparam int unsigned WORD_W = PIX_W * LANES,
    localparam int unsigned BYTES  = WORDS * LANES
) (
    input  logic [WORDS-1:0][WORD_W-1:0] words_i,
    output logic [PIX_W-1:0]             stream_o [BYTES]
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Map lane l of word w to stream position w*LANES+l.
            always_comb stream_o[w*LANES+l] = words_i[w][l*PIX_W +: PIX_W];
        end
    end
endmodule

// File: rtl/window_select.sv
`timescale 1ns/1ps
// Module: window_select
// Picks TAPS consecutive stream bytes starting at the byte offset.
// Assumes TAPS + LANES - 1 <= BYTES so no index runs past the stream.
module window_select #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned BYTES = 12,
    parameter int unsigned TAPS  = 9,
    localparam int unsigned OFS_W = $clog2(LANES),
    localparam int unsigned IDX_W = $clog2(BYTES)
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [PIX_W-1:0] stream_i [BYTES],
    output logic [PIX_W-1:0] tap_o    [TAPS]
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic [IDX_W-1:0] idx;
        // Stream position feeding tap t for the current offset.
        always_comb idx = IDX_W'(t) + IDX_W'(ofs_i);
        // Per-tap multiplexer over the stream.
        always_comb tap_o[t] = stream_i[idx];
    end
endmodule

// File: rtl/row_pack.sv
`timescale 1ns/1ps
// Module: row_pack
// Packs the window taps into the row words and the one-pixel-shifted words.
// Assumes TAPS = 2*LANES + 1 and tap 0 is the first pixel of the row.
module row_pack #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned LANES = 4,
    localparam int unsigned WORD_W = PIX_W * LANES,
    localparam int unsigned TAPS   = 2 * LANES + 1
) (
    input  logic [PIX_W-1:0]  tap_i [TAPS],
    output logic [WORD_W-1:0] row_w0_o,
    output logic [WORD_W-1:0] row_w1_o,
    output logic [WORD_W-1:0] nxt_w0_o,
    output logic [WORD_W-1:0] nxt_w1_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Unshifted row: taps 0..2*LANES-1.
        always_comb row_w0_o[l*PIX_W +: PIX_W] = tap_i[l];
        always_comb row_w1_o[l*PIX_W +: PIX_W] = tap_i[LANES + l];
        // Shifted row: taps 1..2*LANES.
        always_comb nxt_w0_o[l*PIX_W +: PIX_W] = tap_i[l + 1];
        always_comb nxt_w1_o[l*PIX_W +: PIX_W] = tap_i[LANES + l + 1];
    end
endmodule

// File: rtl/row_byte_aligner.sv
`timescale 1ns/1ps
// Module: row_byte_aligner (top)
// Turns three aligned fetch words plus a byte offset into one row of eight
// pixels and its one-pixel-shifted copy, as four packed words.
// Assumes the fetch address is the source address with the low bits cleared,
// and the offset is the source address modulo LANES. Purely combinational.
module row_byte_aligner
    import row_aligner_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_W_DEF,
    parameter int unsigned LANES = LANES_DEF,
    localparam int unsigned WORD_W = PIX_W * LANES,
    localparam int unsigned OFS_W  = $clog2(LANES),
    localparam int unsigned TAPS   = 2 * LANES + 1,
    localparam int unsigned WORDS  = words_needed(TAPS, LANES),
    localparam int unsigned BYTES  = WORDS * LANES
) (
    input  logic [OFS_W-1:0]  byte_ofs_i,
    input  logic [WORD_W-1:0] fetch_w0_i,
    input  logic [WORD_W-1:0] fetch_w1_i,
    input  logic [WORD_W-1:0] fetch_w2_i,
    output logic [WORD_W-1:0] row_w0_o,
    output logic [WORD_W-1:0] row_w1_o,
    output logic [WORD_W-1:0] nxt_w0_o,
    output logic [WORD_W-1:0] nxt_w1_o
);
    logic [WORDS-1:0][WORD_W-1:0] words;
    logic [PIX_W-1:0]             stream [BYTES];
    logic [PIX_W-1:0]             taps   [TAPS];

    // Gather the fetch words, lowest address first.
    always_comb words = {fetch_w2_i, fetch_w1_i, fetch_w0_i};

    fetch_unpack #(.PIX_W(PIX_W), .LANES(LANES), .WORDS(WORDS)) u_unpack (
        .words_i  (words),
        .stream_o (stream)
    );

    window_select #(.PIX_W(PIX_W), .LANES(LANES), .BYTES(BYTES), .TAPS(TAPS)) u_select (
        .ofs_i    (byte_ofs_i),
        .stream_i (stream),
        .tap_o    (taps)
    );

    row_pack #(.PIX_W(PIX_W), .LANES(LANES)) u_pack (
        .tap_i    (taps),
        .row_w0_o (row_w0_o),
        .row_w1_o (row_w1_o),
        .nxt_w0_o (nxt_w0_o),
        .nxt_w1_o (nxt_w1_o)
    );

    // Alternate view of the first and last window pixels, taken straight from the words.
    logic [WORD_W-1:0] w0_shr, w2_shr;
    always_comb begin
        w0_shr = fetch_w0_i >> (PIX_W * byte_ofs_i);
        w2_shr = fetch_w2_i >> (PIX_W * byte_ofs_i);
    end

    // Output checks against the fetch words, skipped while inputs are unknown.
    always_comb begin
        if (!$isunknown({byte_ofs_i, fetch_w0_i, fetch_w1_i, fetch_w2_i})) begin
            assert_first_pixel_R2: assert (row_w0_o[PIX_W-1:0] == w0_shr[PIX_W-1:0])
                else $error("first pixel does not come from fetch word 0 at the offset");
            assert_last_pixel_R5: assert (nxt_w1_o[WORD_W-1 -: PIX_W] == w2_shr[PIX_W-1:0])
                else $error("last window pixel does not come from fetch word 2 at the offset");
            if (byte_ofs_i == '0) begin
                assert_aligned_pass_R6: assert (row_w0_o == fetch_w0_i && row_w1_o == fetch_w1_i)
                    else $error("aligned row is not a passthrough");
            end
            if (byte_ofs_i == OFS_W'(LANES - 1)) begin
                assert_last_ofs_pass_R7: assert (nxt_w0_o == fetch_w1_i && nxt_w1_o == fetch_w2_i)
                    else $error("shifted row at the top offset is not a passthrough");
            end
        end
    end
endmodule

// File: tb/tb_row_byte_aligner.sv
`timescale 1ns/1ps
// Bench for row_byte_aligner: a byte-list reference model, compared every clock.
module tb_row_byte_aligner;
    localparam real CLK_HALF = 4.0; // 125 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ofs = '0;
    logic [31:0] w0 = '0, w1 = '0, w2 = '0;
    logic [31:0] r0, r1, n0, n1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    row_byte_aligner dut (
        .byte_ofs_i (ofs),
        .fetch_w0_i (w0),
        .fetch_w1_i (w1),
        .fetch_w2_i (w2),
        .row_w0_o   (r0),
        .row_w1_o   (r1),
        .nxt_w0_o   (n0),
        .nxt_w1_o   (n1)
    );

    // Reference: stream byte k is byte k%4 of word k/4 (R1); gather 4 bytes from start.
    function automatic logic [31:0] ref_word(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] c, input int start);
        logic [7:0] q[$];
        logic [31:0] res = '0;
        for (int k = 0; k < 4; k++) q.push_back(a[8*k +: 8]);
        for (int k = 0; k < 4; k++) q.push_back(b[8*k +: 8]);
        for (int k = 0; k < 4; k++) q.push_back(c[8*k +: 8]);
        for (int j = 0; j < 4; j++) res[8*j +: 8] = q[start + j];
        return res;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h (ofs=%0d)", req, what, act, exp, ofs);
        end
    endtask

    // Drive one input set just after a rising edge.
    task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c);
        @(posedge clk);
        #1;
        ofs = o; w0 = a; w1 = b; w2 = c;
    endtask

    // Compare all four outputs with the model at the falling edge (R2..R5, R9).
    task automatic compare_all();
        int s;
        @(negedge clk);
        s = int'(ofs);
        check("R2", "row_w0", r0, ref_word(w0, w1, w2, s));
        check("R3", "row_w1", r1, ref_word(w0, w1, w2, s + 4));
        check("R4", "nxt_w0", n0, ref_word(w0, w1, w2, s + 1));
        check("R5", "nxt_w1", n1, ref_word(w0, w1, w2, s + 5));
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 200000.0);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c, hold0, hold1, hold2, hold3;
        // Reset phase: zero inputs give zero outputs (R9, no stored state).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "reset row_w0", r0, 32'h0);
        check("R9", "reset nxt_w1", n1, 32'h0);
        rst_n = 1'b1;

        // R1: distinct incrementing bytes at every offset.
        for (int o = 0; o < 4; o++) begin
            apply(2'(o), 32'h03020100, 32'h07060504, 32'h0b0a0908);
            compare_all();
        end

        // R6: aligned passthrough and shifted merge.
        apply(2'd0, 32'hDDCCBBAA, 32'h44332211, 32'h99887766);
        @(negedge clk);
        check("R6", "row_w0 pass", r0, 32'hDDCCBBAA);
        check("R6", "row_w1 pass", r1, 32'h44332211);
        check("R6", "nxt_w0 merge", n0, 32'h11DDCCBB);
        check("R6", "nxt_w1 merge", n1, 32'h66443322);

        // R7: top offset takes shifted words straight from words 1 and 2.
        apply(2'd3, 32'hDDCCBBAA, 32'h44332211, 32'h99887766);
        @(negedge clk);
        check("R7", "nxt_w0 pass", n0, 32'h44332211);
        check("R7", "nxt_w1 pass", n1, 32'h99887766);
        check("R7", "row_w0 low byte", {24'h0, r0[7:0]}, 32'h000000DD);

        // All-ones and alternating patterns.
        for (int o = 0; o < 4; o++) begin
            apply(2'(o), 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF);
            compare_all();
            apply(2'(o), 32'h5A5AA5A5, 32'hA5A55A5A, 32'h0F0FF0F0);
            compare_all();
        end

        // Random sweep: new offset and words every cycle (R2..R5, R9).
        for (int i = 0; i < 3000; i++) begin
            apply(2'($urandom_range(0, 3)), $urandom, $urandom, $urandom);
            compare_all();
        end

        // R8: change only bytes outside the window; outputs must not move.
        for (int i = 0; i < 400; i++) begin
            int o;
            o = i % 4;
            a = $urandom; b = $urandom; c = $urandom;
            apply(2'(o), a, b, c);
            @(negedge clk);
            hold0 = r0; hold1 = r1; hold2 = n0; hold3 = n1;
            for (int k = 0; k < 12; k++) begin
                if (k < o || k > o + 8) begin
                    logic [7:0] rb;
                    rb = 8'($urandom);
                    if (k < 4) a[8*k +: 8] = rb;
                    else if (k < 8) b[8*(k-4) +: 8] = rb;
                    else c[8*(k-8) +: 8] = rb;
                end
            end
            apply(2'(o), a, b, c);
            @(negedge clk);
            check("R8", "row_w0 stable", r0, hold0);
            check("R8", "row_w1 stable", r1, hold1);
            check("R8", "nxt_w0 stable", n0, hold2);
            check("R8", "nxt_w1 stable", n1, hold3);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule